// File: doc/BRIEF.md
# Programmable Read-Only Memory Device Model

A synthesizable, clock-cycle model of a byte-wide programmable read-only memory. It serves as the device under program when a programmer controller is verified. Analog levels are reduced to flags: `prog_hv` marks the raised programming supply and `id_hv` marks the raised voltage on the identifier address line. The two active-low strobes `ce_n` and `oe_n` pick among seven operating modes. These are read, output-disable, standby, program, program-inhibit, verify and identifier readout.

The store powers up blank, with every bit at one. Each program pulse ANDs the applied byte into the addressed location, so a pulse can clear bits but never set them. A build parameter chooses between the window-erasable variant and the one-time variant; only the erasable one obeys `erase`. One configurable "weak" location takes several pulses before its bits clear, so a programmer's retry loop has something to retry against. Read data appears a parameterised number of clocks after the address or mode settles. The bus stops being driven at the first clock that sees a strobe rise.

Top module: `eprom_model`

## Requirements
- R1: Reset (synchronous, active low) leaves `dout_oe` low and every byte of the store at all ones, and clears the weak-location pulse count.
- R2: Mode decode. With `ce_n`=1: `prog_hv`=1 and `oe_n`=0 gives verify; `prog_hv`=1 and `oe_n`=1 gives inhibit; anything else gives standby. With `ce_n`=0 and `oe_n`=0: `id_hv`=1 gives identifier readout, otherwise read. With `ce_n`=0 and `oe_n`=1: `prog_hv`=1 gives program, otherwise output-disable.
- R3: In read mode the byte stored at `addr` is driven on `dout` with `dout_oe`=1.
- R4: In standby, output-disable, program and inhibit, `dout_oe` is 0 from the first clock edge that sees that mode.
- R5: Entering program mode, meaning a clock in program mode whose previous clock was in another mode, is one pulse. The pulse replaces the addressed byte with its AND with `din`. Staying in program mode gives no further pulse, and a pulse never turns a 0 bit into a 1.
- R6: In verify mode the byte stored at `addr` is driven with `dout_oe`=1.
- R7: In identifier mode `dout` is MFG_ID (default 0x97) when `addr[0]`=0 and DEV_ID (default 0x04) when `addr[0]`=1, whatever the store holds.
- R8: Location WEAK_ADDR ignores its first WEAK_PULSES-1 pulses; the pulse that completes the count and every later one apply normally.
- R9: With ERASABLE=1, a clock with `erase`=1 sets every byte to all ones and clears the weak pulse count. With ERASABLE=0, `erase` changes nothing.
- R10: A change of `addr` or of mode drops `dout_oe` at the first clock edge that sees it. For a driving mode, `dout_oe` rises with valid data at the ACC_LAT-th edge after that one.
- R11: Inhibit mode leaves the store unchanged whatever `din` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable / power-down strobe, active low |
| oe_n | input | 1 | Output enable strobe, active low |
| prog_hv | input | 1 | Programming supply is at its raised level |
| id_hv | input | 1 | Identifier address line is at its raised voltage |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Data presented for programming |
| erase | input | 1 | Erase exposure (erasable variant only) |
| dout | output | DATA_W | Data driven toward the bus |
| dout_oe | output | 1 | Bus drive enable; bus floats when low |

## Verification
The bench builds two copies side by side with ADDR_W=6, ACC_LAT=3, WEAK_ADDR=5 and WEAK_PULSES=3. One copy is erasable and the other is one-time. The 64-byte store and the three-pulse weak location keep the retry path within a handful of vectors. The three-cycle latency leaves room to observe the floating window on every address change. Running both variants on the same stimulus brings the difference after an erase into direct view. The erasable copy returns to blank and restarts its weak count. The one-time copy keeps its cleared bits and applies the next weak pulse at once.

// File: rtl/eprom_pkg.sv
// Shared types for the programmable read-only memory model.
package eprom_pkg;

    // Operating modes decoded from the strobes and the high-voltage flags.
    typedef enum logic [2:0] {
        MD_STANDBY = 3'd0,
        MD_INHIBIT = 3'd1,
        MD_OUTDIS  = 3'd2,
        MD_READ    = 3'd3,
        MD_PROGRAM = 3'd4,
        MD_VERIFY  = 3'd5,
        MD_IDENT   = 3'd6
    } mode_t;

endpackage

// File: rtl/eprom_mode_dec.sv
// Mode decoder.
// Turns the two active-low strobes and the two raised-voltage flags into one
// operating mode, and says whether that mode drives the data bus.
// Assumes: the flags are already clean digital levels; purely combinational.
module eprom_mode_dec
    import eprom_pkg::*;
(
    input  logic  ce_n,
    input  logic  oe_n,
    input  logic  prog_hv,
    input  logic  id_hv,
    output mode_t mode,
    output logic  drive_req
);

    // Priority decode: chip enable first, then output enable, then flags.
    always_comb begin
        if (ce_n) begin
            if (prog_hv && !oe_n)      mode = MD_VERIFY;
            else if (prog_hv)          mode = MD_INHIBIT;
            else                       mode = MD_STANDBY;
        end else if (!oe_n) begin
            mode = id_hv ? MD_IDENT : MD_READ;
        end else begin
            mode = prog_hv ? MD_PROGRAM : MD_OUTDIS;
        end
    end

    // Only read, verify and identifier readout put data on the bus.
    assign drive_req = (mode == MD_READ) || (mode == MD_VERIFY) || (mode == MD_IDENT);

endmodule

// File: rtl/eprom_array.sv
// Storage array with clear-only programming, optional erase and one weak byte.
// Each write pulse ANDs wr_data into the addressed byte. The byte at WEAK_ADDR
// counts pulses and accepts only from the WEAK_PULSES-th one on.
// Assumes: DEPTH = 2**ADDR_W; erase wins over a pulse in the same clock.
module eprom_array #(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 8,
    parameter int WEAK_ADDR   = 0,
    parameter int WEAK_PULSES = 1,
    parameter bit ERASABLE    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_pulse,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              erase,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int WK_W  = (WEAK_PULSES > 1) ? $clog2(WEAK_PULSES) : 1;
    localparam logic [WK_W-1:0] WK_LAST = WK_W'(WEAK_PULSES - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [WK_W-1:0]   wk_cnt;
    logic              erase_eff;
    logic              weak_hit;
    logic              weak_ready;
    logic              apply;

    // The one-time variant has no erase path.
    generate
        if (ERASABLE) begin : g_erasable
            assign erase_eff = erase;
        end else begin : g_one_time
            assign erase_eff = erase & 1'b0;
        end
    endgenerate

    assign weak_hit   = wr_pulse && (wr_addr == ADDR_W'(WEAK_ADDR));
    assign weak_ready = (wk_cnt == WK_LAST);
    assign apply      = wr_pulse && (!weak_hit || weak_ready);
    assign rd_data    = mem[rd_addr];

    // Store update: blank on reset or erase, clear-only AND on an accepted pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || erase_eff) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '1;
            end
        end else if (apply) begin
            mem[wr_addr] <= mem[wr_addr] & wr_data;
        end
    end

    // Weak-location pulse counter, saturating at the accepting count.
    always_ff @(posedge clk) begin
        if (!rst_n || erase_eff) begin
            wk_cnt <= '0;
        end else if (weak_hit && !weak_ready) begin
            wk_cnt <= wk_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/eprom_out_stage.sv
// Output timing stage.
// Restarts a settle counter whenever the address or mode changes, floats the
// bus at that first edge, and drives the selected byte once ACC_LAT edges
// have passed. Also hands back the previous mode for pulse detection.
// Assumes: ACC_LAT >= 1.
module eprom_out_stage
    import eprom_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 8,
    parameter int ACC_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_t             mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic              drive_req,
    input  logic [DATA_W-1:0] sel_data,
    output mode_t             mode_prev,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);

    localparam int CNT_W = $clog2(ACC_LAT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACC_LAT - 1);

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              changed;
    logic              ready;

    assign changed = (mode != mode_prev) || (addr != addr_q);
    assign ready   = !changed && (cnt_q == CNT_LAST);

    // Remember the last address and mode seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_prev <= MD_STANDBY;
            addr_q    <= '0;
        end else begin
            mode_prev <= mode;
            addr_q    <= addr;
        end
    end

    // Settle counter: restart on change, saturate at the last wait cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || changed) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Bus register: drive only once settled in a driving mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_oe <= 1'b0;
            dout    <= '0;
        end else begin
            dout_oe <= drive_req && ready;
            if (drive_req && ready) begin
                dout <= sel_data;
            end
        end
    end

endmodule

// File: rtl/eprom_model.sv
// Programmable read-only memory device model (top).
// Decodes the mode, issues one program pulse per entry into program mode,
// picks array data or an identifier byte, and times the bus drive.
// Assumes: all inputs synchronous to clk; electrical levels given as flags.
module eprom_model
    import eprom_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 8,
    parameter int ACC_LAT     = 2,
    parameter int WEAK_ADDR   = 37,
    parameter int WEAK_PULSES = 4,
    parameter bit ERASABLE    = 1'b1,
    parameter int MFG_ID      = 'h97,
    parameter int DEV_ID      = 'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              prog_hv,
    input  logic              id_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              erase,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);

    mode_t             mode;
    mode_t             mode_prev;
    logic              drive_req;
    logic              prog_pulse;
    logic [DATA_W-1:0] arr_data;
    logic [DATA_W-1:0] sel_data;

    eprom_mode_dec u_dec (
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .prog_hv   (prog_hv),
        .id_hv     (id_hv),
        .mode      (mode),
        .drive_req (drive_req)
    );

    // One pulse on the first clock of each stay in program mode.
    assign prog_pulse = (mode == MD_PROGRAM) && (mode_prev != MD_PROGRAM);

    eprom_array #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .WEAK_ADDR   (WEAK_ADDR),
        .WEAK_PULSES (WEAK_PULSES),
        .ERASABLE    (ERASABLE)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_pulse (prog_pulse),
        .wr_addr  (addr),
        .wr_data  (din),
        .erase    (erase),
        .rd_addr  (addr),
        .rd_data  (arr_data)
    );

    // Identifier bytes replace array data in identifier mode.
    always_comb begin
        if (mode == MD_IDENT) begin
            sel_data = addr[0] ? DATA_W'(DEV_ID) : DATA_W'(MFG_ID);
        end else begin
            sel_data = arr_data;
        end
    end

    eprom_out_stage #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .ACC_LAT (ACC_LAT)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .addr      (addr),
        .drive_req (drive_req),
        .sel_data  (sel_data),
        .mode_prev (mode_prev),
        .dout      (dout),
        .dout_oe   (dout_oe)
    );

endmodule

// File: rtl/eprom_model_chk.sv
// Port-level checker for eprom_model, attached by bind below.
// Assumes: inputs hold real values from the first clock on.
module eprom_model_chk #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    parameter int MFG_ID = 'h97,
    parameter int DEV_ID = 'h04
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              prog_hv,
    input logic              id_hv,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] dout,
    input logic              dout_oe
);

    // R1: reset leaves the bus undriven.
    a_r1_reset_float: assert property (@(posedge clk)
        !rst_n |=> !dout_oe);

    // R4: standby and inhibit float the bus at the next edge.
    a_r4_standby_float: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && !(prog_hv && !oe_n)) |=> !dout_oe);

    // R4: output-disable and program float the bus at the next edge.
    a_r4_outdis_float: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && oe_n) |=> !dout_oe);

    // R10: an address change drops the drive at the first edge seeing it.
    a_r10_addr_change_float: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(addr) |=> !dout_oe);

    // R7: identifier readout with address bit 0 low returns the maker byte.
    a_r7_maker_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && $past(!ce_n && !oe_n && id_hv && !addr[0]))
            |-> (dout == DATA_W'(MFG_ID)));

    // R7: identifier readout with address bit 0 high returns the device byte.
    a_r7_device_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && $past(!ce_n && !oe_n && id_hv && addr[0]))
            |-> (dout == DATA_W'(DEV_ID)));

endmodule

bind eprom_model eprom_model_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .MFG_ID (MFG_ID),
    .DEV_ID (DEV_ID)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .prog_hv (prog_hv),
    .id_hv   (id_hv),
    .addr    (addr),
    .dout    (dout),
    .dout_oe (dout_oe)
);

// File: tb/tb_eprom_model.sv
`timescale 1ns/1ps
module tb_eprom_model;

    localparam int AW  = 6;
    localparam int DW  = 8;
    localparam int LAT = 3;

    typedef struct packed {
        logic          ce_n;
        logic          oe_n;
        logic          phv;
        logic          idhv;
        logic          ers;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic          eoe;
        logic [DW-1:0] exp_e;
        logic [DW-1:0] exp_o;
        logic [3:0]    req;
    } vec_t;

    // Mode columns: read 0000, outdis 0100, standby 1000, program 0110,
    // verify 1010, inhibit 1110, identifier 0001.
    localparam vec_t TBL [26] = '{
        '{1'b0,1'b0,1'b0,1'b0,1'b0,6'd3,8'h00,1'b1,8'hFF,8'hFF,4'd3},  // R3 blank read
        '{1'b0,1'b1,1'b0,1'b0,1'b0,6'd3,8'h00,1'b0,8'h00,8'h00,4'd2},  // R2 output-disable
        '{1'b1,1'b0,1'b0,1'b0,1'b0,6'd3,8'h00,1'b0,8'h00,8'h00,4'd4},  // R4 standby
        '{1'b0,1'b1,1'b1,1'b0,1'b0,6'd3,8'hA5,1'b0,8'h00,8'h00,4'd5},  // R5 program
        '{1'b1,1'b0,1'b1,1'b0,1'b0,6'd3,8'h00,1'b1,8'hA5,8'hA5,4'd6},  // R6 verify
        '{1'b0,1'b1,1'b1,1'b0,1'b0,6'd3,8'h5A,1'b0,8'h00,8'h00,4'd5},  // R5 second pulse
        '{1'b0,1'b0,1'b0,1'b0,1'b0,6'd3,8'h00,1'b1,8'h00,8'h00,4'd5},  // R5 AND result
        '{1'b0,1'b1,1'b1,1'b0,1'b0,6'd9,8'hF0,1'b0,8'h00,8'h00,4'd5},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,6'd9,8'h00,1'b0,8'h00,8'h00,4'd4},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,6'd9,8'hFF,1'b0,8'h00,8'h00,4'd5},  // R5 try to set
        '{1'b0,1'b0,1'b0,1'b0,1'b0,6'd9,8'h00,1'b1,8'hF0,8'hF0,4'd5},  // R5 no bit set
        '{1'b1,1'b1,1'b1,1'b0,1'b0,6'd9,8'h00,1'b0,8'h00,8'h00,4'd11}, // R11 inhibit
        '{1'b0,1'b0,1'b0,1'b0,1'b0,6'd9,8'h00,1'b1,8'hF0,8'hF0,4'd11}, // R11 unchanged
        '{1'b0,1'b0,1'b0,1'b1,1'b0,6'd0,8'h00,1'b1,8'h97,8'h97,4'd7},  // R7 maker
        '{1'b0,1'b0,1'b0,1'b1,1'b0,6'd1,8'h00,1'b1,8'h04,8'h04,4'd7},  // R7 device
        '{1'b0,1'b0,1'b0,1'b1,1'b0,6'd3,8'h00,1'b1,8'h04,8'h04,4'd7},  // R7 ignores array
        '{1'b0,1'b1,1'b1,1'b0,1'b0,6'd5,8'h0F,1'b0,8'h00,8'h00,4'd8},  // R8 pulse 1
        '{1'b0,1'b0,1'b0,1'b0,1'b0,6'd5,8'h00,1'b1,8'hFF,8'hFF,4'd8},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,6'd5,8'h0F,1'b0,8'h00,8'h00,4'd8},  // R8 pulse 2
        '{1'b0,1'b0,1'b0,1'b0,1'b0,6'd5,8'h00,1'b1,8'hFF,8'hFF,4'd8},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,6'd5,8'h0F,1'b0,8'h00,8'h00,4'd8},  // R8 pulse 3
        '{1'b0,1'b0,1'b0,1'b0,1'b0,6'd5,8'h00,1'b1,8'h0F,8'h0F,4'd8},  // R8 accepted
        '{1'b1,1'b0,1'b0,1'b0,1'b1,6'd3,8'h00,1'b0,8'h00,8'h00,4'd9},  // R9 erase
        '{1'b0,1'b0,1'b0,1'b0,1'b0,6'd3,8'h00,1'b1,8'hFF,8'h00,4'd9},  // R9 blank vs kept
        '{1'b0,1'b1,1'b1,1'b0,1'b0,6'd5,8'h00,1'b0,8'h00,8'h00,4'd9},  // R9 weak recount
        '{1'b0,1'b0,1'b0,1'b0,1'b0,6'd5,8'h00,1'b1,8'hFF,8'h00,4'd9}
    };

    logic          clk = 1'b0;
    logic          rst_n, ce_n, oe_n, prog_hv, id_hv, erase;
    logic [AW-1:0] addr;
    logic [DW-1:0] din;
    logic [DW-1:0] dout_e, dout_o;
    logic          oe_e, oe_o;
    int            checks = 0;
    int            failures = 0;

    always #4 clk = ~clk;

    eprom_model #(.ADDR_W(AW), .DATA_W(DW), .ACC_LAT(LAT), .WEAK_ADDR(5),
                  .WEAK_PULSES(3), .ERASABLE(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .prog_hv(prog_hv),
        .id_hv(id_hv), .addr(addr), .din(din), .erase(erase),
        .dout(dout_e), .dout_oe(oe_e));

    eprom_model #(.ADDR_W(AW), .DATA_W(DW), .ACC_LAT(LAT), .WEAK_ADDR(5),
                  .WEAK_PULSES(3), .ERASABLE(1'b0)) dut_otp (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .prog_hv(prog_hv),
        .id_hv(id_hv), .addr(addr), .din(din), .erase(erase),
        .dout(dout_o), .dout_oe(oe_o));

    // Compare {drive, data}; data is ignored when no drive is expected.
    task automatic chk(input string tag, input logic oe, input logic [DW-1:0] d,
                       input logic eoe, input logic [DW-1:0] ed);
        logic [DW:0] act;
        logic [DW:0] exp;
        act = {oe, eoe ? d : 8'h00};
        exp = {eoe, eoe ? ed : 8'h00};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: got oe/data %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        ce_n = v.ce_n; oe_n = v.oe_n; prog_hv = v.phv; id_hv = v.idhv;
        erase = v.ers; addr = v.a; din = v.d;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; prog_hv = 1'b0; id_hv = 1'b0;
        erase = 1'b0; addr = '0; din = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset float", oe_e, dout_e, 1'b0, 8'h00);
        rst_n = 1'b1;

        // Vector walk: apply, let LAT+1 edges pass, sample at the falling edge.
        for (int i = 0; i < 26; i++) begin
            @(negedge clk);
            drive(TBL[i]);
            repeat (LAT + 1) @(posedge clk);
            @(negedge clk);
            chk($sformatf("R%0d vec%0d erasable", TBL[i].req, i), oe_e, dout_e,
                TBL[i].eoe, TBL[i].exp_e);
            chk($sformatf("R%0d vec%0d one-time", TBL[i].req, i), oe_o, dout_o,
                TBL[i].eoe, TBL[i].exp_o);
        end

        // R10: latency count after an address change in identifier mode.
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; prog_hv = 1'b0; id_hv = 1'b1; addr = 6'd0;
        repeat (LAT + 1) @(posedge clk);
        @(negedge clk);
        chk("R10 settled maker", oe_e, dout_e, 1'b1, 8'h97);
        addr = 6'd1;
        @(posedge clk);
        @(negedge clk);
        chk("R10 float at first edge", oe_e, dout_e, 1'b0, 8'h00);
        repeat (LAT - 1) @(posedge clk);
        @(negedge clk);
        chk("R10 still floating before latency", oe_e, dout_e, 1'b0, 8'h00);
        @(posedge clk);
        @(negedge clk);
        chk("R10 data at latency edge", oe_e, dout_e, 1'b1, 8'h04);

        // R4/R10: output enable rising floats the bus one edge later.
        oe_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R4 float after output enable rises", oe_e, dout_e, 1'b0, 8'h00);

        // R1: mid-run reset returns both variants to blank.
        id_hv = 1'b0; oe_n = 1'b0; addr = 6'd3; rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 reset float mid-run", oe_e, dout_e, 1'b0, 8'h00);
        rst_n = 1'b1;
        repeat (LAT + 1) @(posedge clk);
        @(negedge clk);
        chk("R1 blank after reset erasable", oe_e, dout_e, 1'b1, 8'hFF);
        chk("R1 blank after reset one-time", oe_o, dout_o, 1'b1, 8'hFF);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule